// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire bus slave that keeps three configuration registers for a programmable clock generator. Those registers are a 16-bit divider word, a 16-bit mode word and an 8-bit bus-control byte. A fast system clock samples the bus clock and data lines. The slave pulls the data line low through an open-drain enable. The live register values drive the clock-generation logic directly. A power-down status input blocks register writes while the generator is shut down.

The master first sends an address byte and then a command byte. The command byte either picks the register that the following data bytes go to or come from, or it requests a save. A save copies all three registers into a nonvolatile shadow bank. The bank takes a set number of system clocks to finish a save, and the slave refuses every transfer until it is done. At reset the live registers reload from that shadow bank. A save starts when a transfer ends, either automatically or only on command, depending on a bit in the bus-control byte.

Top module: `cfg_twi_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper nibble is 4'b1011 and bits 3..1 equal bus-control bits 2..0. Bit 0 is the direction (1 = read, 0 = write). For any other address byte the data line stays released for the rest of the transfer.
- R2: Command 0x01 selects the divider word, 0x02 the mode word and 0x0D the bus-control byte. Data bytes that follow are acknowledged and written, most significant byte first. A byte beyond the size of the register is not acknowledged.
- R3: A write that stops after the most significant byte of a 16-bit register leaves its low byte unchanged. Mode bit 15 and bus-control bits 7..4 always read as zero.
- R4: A read is a command write, then a repeated START, then the address byte with direction 1. The slave then sends the selected register most significant byte first and moves to the next byte after each master acknowledge. After a master not-acknowledge the slave releases the data line.
- R5: With bus-control bit 3 equal to 0, a transfer that wrote data starts a save when it ends with STOP or repeated START. With bit 3 equal to 1, only command 0x3F starts a save. Any write to the bus-control byte starts a save whatever bit 3 holds.
- R6: For SAVE_CYCLES system clocks after a save starts, the slave refuses every address byte, including its own.
- R7: Reset loads the live registers from the shadow bank. The shadow bank starts with divider 0x0000, mode 0x1800 and bus-control 0x00.
- R8: An unknown command byte is not acknowledged, and the data that follows it changes no register.
- R9: While the power-down input is high, data bytes of a write are not acknowledged and change no register.
- R10: A START that arrives in the middle of a byte abandons that byte and begins reception of a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| pwr_down_i | input | 1 | Clock generator is in power-down |
| div_o | output | 16 | Live divider word |
| mux_o | output | 16 | Live mode word |
| bus_o | output | 8 | Live bus-control byte |

## Verification
Each bus line passes through two synchronizer flops and one edge register, and the open-drain enable is registered once more. The slave's drive therefore changes about four system clocks after the bus-clock edge that causes it. The bench gives every bus phase ten system clocks and samples the data line in the middle of the clock-high phase, well after that delay. Register outputs change one clock after the acknowledge decision, and a save begins one clock after STOP is detected, so the bench reads the outputs only after a complete transfer. Busy refusals are probed within the first few hundred clocks of the save window, and retries wait past its end.

// File: rtl/cfg_twi_pkg.sv
package cfg_twi_pkg;

    localparam logic [3:0]  DEV_TYPE = 4'b1011;
    localparam logic [7:0]  CMD_DIV  = 8'h01;
    localparam logic [7:0]  CMD_MUX  = 8'h02;
    localparam logic [7:0]  CMD_BUS  = 8'h0D;
    localparam logic [7:0]  CMD_SAVE = 8'h3F;
    localparam logic [15:0] DEF_DIV  = 16'h0000;
    localparam logic [15:0] DEF_MUX  = 16'h1800;
    localparam logic [7:0]  DEF_BUS  = 8'h00;

    typedef enum logic [2:0] {
        SEL_DIV, SEL_MUX, SEL_BUS, SEL_SAVE, SEL_NONE
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_TX, ST_SKIP
    } twi_st_e;

    typedef struct packed {
        logic       en;
        reg_sel_e   sel;
        logic       lo;
        logic [7:0] data;
    } wr_req_t;

    function automatic reg_sel_e decode_cmd(input logic [7:0] c);
        case (c)
            CMD_DIV:  return SEL_DIV;
            CMD_MUX:  return SEL_MUX;
            CMD_BUS:  return SEL_BUS;
            CMD_SAVE: return SEL_SAVE;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] read_byte(input reg_sel_e s, input logic [1:0] i,
                                             input logic [15:0] d, input logic [15:0] m,
                                             input logic [7:0] b);
        case (s)
            SEL_DIV: return (i == 2'd0) ? d[15:8] : (i == 2'd1) ? d[7:0] : 8'hFF;
            SEL_MUX: return (i == 2'd0) ? m[15:8] : (i == 2'd1) ? m[7:0] : 8'hFF;
            SEL_BUS: return (i == 2'd0) ? b : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s    = scl_sh[STAGES-1];
    assign sda_s    = sda_sh[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_proto.sv
module twi_proto
    import cfg_twi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_s,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_ev,
    input  logic        stop_ev,
    input  logic        save_busy_i,
    input  logic        pwr_down_i,
    input  logic [15:0] div_i,
    input  logic [15:0] mux_i,
    input  logic [7:0]  bus_i,
    output logic        sda_oe,
    output wr_req_t     wr,
    output logic        save_go
);
    twi_st_e    state;
    reg_sel_e   sel, dec;
    logic [3:0] cnt;
    logic [7:0] sh, txb;
    logic [1:0] idx;
    logic       ackd, dirty, save_req, acc;
    twi_st_e    nxt;

    always_comb begin
        acc = 1'b0;
        nxt = ST_SKIP;
        dec = decode_cmd(sh);
        case (state)
            ST_ADDR: begin
                acc = (sh[7:4] == DEV_TYPE) && (sh[3:1] == bus_i[2:0]) && !save_busy_i;
                nxt = sh[0] ? ST_TX : ST_CMD;
            end
            ST_CMD: begin
                acc = (dec != SEL_NONE);
                nxt = ST_WDATA;
            end
            ST_WDATA: begin
                acc = !pwr_down_i &&
                      ((((sel == SEL_DIV) || (sel == SEL_MUX)) && (idx < 2'd2)) ||
                       ((sel == SEL_BUS) && (idx == 2'd0)));
                nxt = ST_WDATA;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sel      <= SEL_NONE;
            cnt      <= '0;
            sh       <= '0;
            txb      <= 8'hFF;
            idx      <= '0;
            ackd     <= 1'b0;
            dirty    <= 1'b0;
            save_req <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
            save_go  <= 1'b0;
        end else begin
            wr.en   <= 1'b0;
            save_go <= 1'b0;
            if (start_ev || stop_ev) begin
                save_go  <= save_req | (dirty & ~bus_i[3]);
                save_req <= 1'b0;
                dirty    <= 1'b0;
                sda_oe   <= 1'b0;
                cnt      <= '0;
                idx      <= '0;
                state    <= start_ev ? ST_ADDR : ST_IDLE;
            end else if (scl_rise) begin
                if (state == ST_TX) begin
                    if (cnt < 4'd8) begin
                        cnt <= cnt + 4'd1;
                    end else if (!sda_s) begin
                        txb <= read_byte(sel, idx, div_i, mux_i, bus_i);
                        idx <= (idx == 2'd3) ? idx : idx + 2'd1;
                        cnt <= '0;
                    end else begin
                        state <= ST_SKIP;
                    end
                end else if ((state == ST_ADDR || state == ST_CMD || state == ST_WDATA)
                             && cnt < 4'd8) begin
                    sh  <= {sh[6:0], sda_s};
                    cnt <= cnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (state == ST_TX) begin
                    sda_oe <= (cnt < 4'd8) ? ~txb[3'd7 - cnt[2:0]] : 1'b0;
                end else if (state == ST_ADDR || state == ST_CMD || state == ST_WDATA) begin
                    if (cnt == 4'd8) begin
                        sda_oe <= acc;
                        ackd   <= acc;
                        cnt    <= 4'd9;
                        if (acc) begin
                            case (state)
                                ST_ADDR: if (sh[0]) begin
                                    txb <= read_byte(sel, 2'd0, div_i, mux_i, bus_i);
                                    idx <= 2'd1;
                                end
                                ST_CMD: begin
                                    sel <= dec;
                                    idx <= '0;
                                    if (dec == SEL_SAVE) save_req <= 1'b1;
                                end
                                default: begin
                                    wr    <= '{en: 1'b1, sel: sel, lo: idx[0], data: sh};
                                    idx   <= idx + 2'd1;
                                    dirty <= 1'b1;
                                    if (sel == SEL_BUS) save_req <= 1'b1;
                                end
                            endcase
                        end else if (state == ST_CMD) begin
                            sel <= SEL_NONE;
                        end
                    end else if (cnt == 4'd9) begin
                        cnt    <= '0;
                        state  <= ackd ? nxt : ST_SKIP;
                        sda_oe <= (ackd && nxt == ST_TX) ? ~txb[7] : 1'b0;
                    end
                end
            end
        end
    end

    // R4
    oe_quiet_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R6
    busy_addr_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && cnt == 4'd9 && save_busy_i) |-> !sda_oe);

    // R9
    pd_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> !$past(pwr_down_i));
endmodule

// File: rtl/twi_cfg_bank.sv
module twi_cfg_bank
    import cfg_twi_pkg::*;
#(
    parameter int SAVE_CYCLES = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  wr_req_t     wr,
    input  logic        save_go,
    output logic [15:0] div_o,
    output logic [15:0] mux_o,
    output logic [7:0]  bus_o,
    output logic        busy_o
);
    localparam int CW = $clog2(SAVE_CYCLES + 1);

    logic [15:0] nv_div = DEF_DIV;
    logic [15:0] nv_mux = DEF_MUX;
    logic [7:0]  nv_bus = DEF_BUS;
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_o    <= nv_div;
            mux_o    <= nv_mux;
            bus_o    <= nv_bus;
            busy_cnt <= '0;
        end else begin
            if (save_go) begin
                nv_div   <= div_o;
                nv_mux   <= mux_o;
                nv_bus   <= bus_o;
                busy_cnt <= CW'(SAVE_CYCLES);
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (wr.en) begin
                case (wr.sel)
                    SEL_DIV: if (wr.lo) div_o[7:0] <= wr.data; else div_o[15:8] <= wr.data;
                    SEL_MUX: if (wr.lo) mux_o[7:0] <= wr.data; else mux_o[15:8] <= {1'b0, wr.data[6:0]};
                    SEL_BUS: bus_o <= {4'b0000, wr.data[3:0]};
                    default: ;
                endcase
            end
        end
    end

    assign busy_o = (busy_cnt != '0);

    // R3
    resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mux_o[15] && (bus_o[7:4] == 4'b0000));

    // R6
    save_idle_chk: assert property (@(posedge clk) disable iff (rst)
        save_go |-> !busy_o);

    // R5
    save_start_chk: assert property (@(posedge clk) disable iff (rst)
        save_go |=> busy_o);
endmodule

// File: rtl/cfg_twi_slave.sv
module cfg_twi_slave
    import cfg_twi_pkg::*;
#(
    parameter int SAVE_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic        pwr_down_i,
    output logic [15:0] div_o,
    output logic [15:0] mux_o,
    output logic [7:0]  bus_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, busy, save_go;
    wr_req_t wr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    twi_proto u_proto (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .save_busy_i(busy), .pwr_down_i(pwr_down_i),
        .div_i(div_o), .mux_i(mux_o), .bus_i(bus_o),
        .sda_oe(sda_oe_o), .wr(wr), .save_go(save_go)
    );

    twi_cfg_bank #(.SAVE_CYCLES(SAVE_CYCLES)) u_bank (
        .clk(clk), .rst(rst), .wr(wr), .save_go(save_go),
        .div_o(div_o), .mux_o(mux_o), .bus_o(bus_o), .busy_o(busy)
    );
endmodule

// File: tb/sim_cfg_twi_slave.sv
module sim_cfg_twi_slave;
    localparam int SAVE = 600;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic pwr_down = 1'b0;
    logic sda_oe;
    logic [15:0] div_o, mux_o;
    logic [7:0]  bus_o;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    cfg_twi_slave #(.SAVE_CYCLES(SAVE)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .pwr_down_i(pwr_down), .div_o(div_o), .mux_o(mux_o), .bus_o(bus_o)
    );

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic b_start();
        m_sda = 1'b1; wc(Q); scl = 1'b1; wc(Q); m_sda = 1'b0; wc(Q); scl = 1'b0; wc(Q/2);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; wc(Q); scl = 1'b1; wc(Q); m_sda = 1'b1; wc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wc(Q); scl = 1'b1; wc(Q); scl = 1'b0; wc(Q/2);
        end
        m_sda = 1'b1; wc(Q); scl = 1'b1; wc(Q/2);
        ack = !sda_line;
        wc(Q/2); scl = 1'b0; wc(Q/2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wc(Q/2); scl = 1'b1; wc(Q/2);
            b[i] = sda_line;
            wc(Q/2); scl = 1'b0; wc(Q/2);
        end
        m_sda = !mack; wc(Q/2); scl = 1'b1; wc(Q); scl = 1'b0; wc(Q/2); m_sda = 1'b1;
    endtask

    task automatic probe(input logic [2:0] dev, output bit ack);
        b_start(); send_byte({4'hB, dev, 1'b0}, ack); b_stop();
    endtask

    task automatic wr_reg(input logic [2:0] dev, input logic [7:0] cmd, input int n,
                          input logic [15:0] v, output logic [3:0] acks);
        bit a;
        acks = '0;
        b_start();
        send_byte({4'hB, dev, 1'b0}, a); acks[0] = a;
        send_byte(cmd, a); acks[1] = a;
        if (n > 0) begin send_byte(v[15:8], a); acks[2] = a; end
        if (n > 1) begin send_byte(v[7:0], a); acks[3] = a; end
        b_stop();
    endtask

    task automatic rd_reg(input logic [2:0] dev, input logic [7:0] cmd, input int n,
                          output logic [15:0] v);
        bit a;
        logic [7:0] b0, b1;
        b_start();
        send_byte({4'hB, dev, 1'b0}, a);
        send_byte(cmd, a);
        b_start();
        send_byte({4'hB, dev, 1'b1}, a);
        b1 = 8'h00;
        recv_byte(n > 1, b0);
        if (n > 1) recv_byte(1'b0, b1);
        b_stop();
        v = {b0, b1};
    endtask

    task automatic do_reset();
        rst = 1'b1; wc(5); rst = 1'b0; wc(5);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit a;
        logic [3:0] acks;
        logic [15:0] v;
        wc(5); rst = 1'b0; wc(5);

        // R7 factory defaults
        check("R7 reset div", div_o, 16'h0000);
        check("R7 reset mux", mux_o, 16'h1800);
        check("R7 reset bus", bus_o, 8'h00);
        check("R1 idle released", sda_oe, 1'b0);

        // R1 sweep of device select with bus bits 2..0 = 0
        for (int d = 0; d < 8; d++) begin
            probe(3'(d), a);
            check($sformatf("R1 devsel %0d", d), a, d == 0);
        end
        b_start(); send_byte(8'hA0, a); b_stop();
        check("R1 wrong type", a, 1'b0);
        check("R1 released after nack", sda_oe, 1'b0);

        // R2 write divider, WC=0 -> save, R6 busy refusal
        wr_reg(3'd0, 8'h01, 2, 16'h1234, acks);
        check("R2 div acks", acks, 4'b1111);
        check("R2 div value", div_o, 16'h1234);
        probe(3'd0, a);
        check("R6 busy nack", a, 1'b0);
        wc(SAVE + 100);
        probe(3'd0, a);
        check("R6 ack after save", a, 1'b1);

        // R4 read back
        rd_reg(3'd0, 8'h01, 2, v);
        check("R4 read div", v, 16'h1234);

        // R3 MSB-only write with reserved bit
        wr_reg(3'd0, 8'h02, 1, 16'hA500, acks);
        check("R3 mux acks", acks[2:0], 3'b111);
        check("R3 mux value", mux_o, 16'h2500);
        wc(SAVE + 100);
        rd_reg(3'd0, 8'h02, 1, v);
        check("R4 read mux msb", v[15:8], 8'h25);
        check("R4 released after master nack", sda_oe, 1'b0);
        rd_reg(3'd0, 8'h0D, 1, v);
        check("R4 read bus", v[15:8], 8'h00);

        // R2 third byte to a 16-bit register refused
        b_start(); send_byte(8'hB0, a); send_byte(8'h01, a);
        send_byte(8'h12, a); send_byte(8'h34, a); send_byte(8'h99, a); b_stop();
        check("R2 extra byte nack", a, 1'b0);
        wc(SAVE + 100);

        // R5 bus write saves regardless; WC=1, address 1
        wr_reg(3'd0, 8'h0D, 1, 16'hF900, acks);
        check("R5 bus acks", acks[2:0], 3'b111);
        check("R3 bus masked", bus_o, 8'h09);
        probe(3'd1, a);
        check("R5 bus write busy", a, 1'b0);
        wc(SAVE + 100);
        probe(3'd0, a);
        check("R1 old addr nack", a, 1'b0);
        probe(3'd1, a);
        check("R1 new addr ack", a, 1'b1);

        // R5 WC=1: no automatic save, divider sweep
        for (int i = 0; i < 8; i++) begin
            logic [15:0] val;
            val = 16'(i * 16'h2491) ^ 16'h5A3C;
            wr_reg(3'd1, 8'h01, 2, val, acks);
            check($sformatf("R2 sweep acks %0d", i), acks, 4'b1111);
            probe(3'd1, a);
            check($sformatf("R5 no save %0d", i), a, 1'b1);
            rd_reg(3'd1, 8'h01, 2, v);
            check($sformatf("R4 sweep read %0d", i), v, val);
            check($sformatf("R2 sweep out %0d", i), div_o, val);
        end

        // R7 reset restores saved copy
        do_reset();
        check("R7 div from shadow", div_o, 16'h1234);
        check("R7 mux from shadow", mux_o, 16'h2500);
        check("R7 bus from shadow", bus_o, 8'h09);

        // R5 standalone save command
        wr_reg(3'd1, 8'h01, 2, 16'h4321, acks);
        wr_reg(3'd1, 8'h3F, 0, 16'h0000, acks);
        check("R5 save cmd ack", acks[1:0], 2'b11);
        probe(3'd1, a);
        check("R5 save cmd busy", a, 1'b0);
        wc(SAVE + 100);
        do_reset();
        check("R5 saved by command", div_o, 16'h4321);

        // R8 unknown command
        wr_reg(3'd1, 8'h05, 2, 16'h5555, acks);
        check("R8 unknown acks", acks, 4'b0001);
        check("R8 div kept", div_o, 16'h4321);
        check("R8 mux kept", mux_o, 16'h2500);
        check("R8 bus kept", bus_o, 8'h09);

        // R9 power-down refuses writes
        pwr_down = 1'b1;
        wr_reg(3'd1, 8'h01, 2, 16'h7777, acks);
        check("R9 pd acks", acks, 4'b0011);
        check("R9 div kept", div_o, 16'h4321);
        pwr_down = 1'b0;

        // R10 START mid-byte
        b_start();
        for (int i = 0; i < 4; i++) begin
            m_sda = i[0]; wc(Q); scl = 1'b1; wc(Q); scl = 1'b0; wc(Q/2);
        end
        b_start();
        send_byte(8'hB2, a); check("R10 addr after abort", a, 1'b1);
        send_byte(8'h01, a);
        send_byte(8'h0A, a);
        send_byte(8'hBC, a);
        b_stop();
        check("R10 write after abort", div_o, 16'h0ABC);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule